// File: doc/BRIEF.md
# Dual-Channel Selectable-Source Event Trigger

This block holds two event channels that work on their own. Each channel watches one line of an input bus. A configuration write picks that line and a trigger condition. The condition can be a level (high or low) or a transition (rising, falling or either). A channel records a pending event when its condition is met.

Software-facing logic reads a channel in one of two ways. A poll strobe returns the pending flag and clears it in the same step. A wait request makes the channel busy until an event arrives, or until a free-running system counter reaches an absolute deadline. The wait result reports whether it ended on a timeout.

The central property is clean reconfiguration. Writing a channel's configuration flushes its input pipeline and its pending flag in the cycle of the write, and it masks detection until the pipeline holds only samples of the new line. A trigger from the old line or the old condition can therefore never end a wait that starts at the same time as the write.

Top module: `evtrig_unit`

## Requirements
- R1: While reset is asserted and right after it, `busy_o`, `done_o`, `timeout_o` and `poll_flag_o` are 0, and `sys_cnt_o` is 0.
- R2: The configuration word is 9 bits wide. Bits 8:6 hold the trigger code and the low log2(NUM_PINS) bits hold the line index. The codes are: 001 rising, 010 falling, 011 either edge, 100 low level, 110 high level. Codes 000, 101 and 111 are off.
- R3: In a level mode, a line that goes active (and stays stable) just after clock edge E0 ends a pending wait with `done_o`=1 and `timeout_o`=0 after edge E0+3, and not earlier.
- R4: In an edge mode, a qualifying transition just after edge E0 ends a pending wait after edge E0+3. A transition that does not match the mode causes no event.
- R5: In an off code no event is ever recorded. Writing an all-zero word to a channel cancels a pending event, so a later poll returns 0.
- R6: A configuration write clears the pending flag and masks detection for three cycles. A level that is already true when the write lands (edge Ec) first shows up in a poll made in the cycle after Ec+3, seen as `poll_flag_o` after edge Ec+4. A wait issued together with a write ends only on the new condition.
- R7: A poll strobe sampled at an edge sets `poll_flag_o` after that edge to the pending state (flag or a detection in that cycle), and it clears the flag. A poll in the same cycle as a configuration write returns 0.
- R8: A wait request sampled at edge W while idle raises `busy_o`. If an event is already pending, `done_o` pulses after edge W+1. A completed wait consumes the event.
- R9: A wait that carries a deadline D with no event ends with `done_o`=1 and `timeout_o`=1 when `sys_cnt_o` reads D+1. An event seen in the same cycle takes priority over the timeout.
- R10: Configuring, polling or waiting on one channel never changes the pending state of the other channel.
- R11: `sys_cnt_o` increments by one every clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | NUM_PINS | Watched input lines |
| sys_cnt_o | output | CNT_W | Free-running system counter |
| cfg_we_i | input | NUM_CH | Per-channel configuration write strobe |
| cfg_word_i | input | 9 | Configuration word (code in bits 8:6, line index in the low bits) |
| poll_req_i | input | NUM_CH | Per-channel poll strobe |
| poll_flag_o | output | NUM_CH | Poll result, valid the cycle after the strobe |
| wait_req_i | input | NUM_CH | Per-channel wait request |
| wait_use_to_i | input | NUM_CH | Wait carries a deadline |
| wait_deadline_i | input | CNT_W | Absolute deadline for the system counter |
| busy_o | output | NUM_CH | Wait in progress |
| done_o | output | NUM_CH | One-cycle pulse when a wait ends |
| timeout_o | output | NUM_CH | Wait ended on the deadline (held until the next end) |

## Verification
A line change made just after an edge passes through two synchronizer flops and a history flop. It ends a wait three edges later, and the bench samples `done_o` one time unit after each of those three edges, so an early result counts as a failure. A configuration write adds a fixed three-cycle mask, which puts a level that is already true at the fourth edge after the write. The bench polls on every cycle around that point. A timeout is due when the counter reads the deadline plus one, and the bench compares `sys_cnt_o` with that value in the cycle where `done_o` rises.

// File: rtl/evtrig_pkg.sv
package evtrig_pkg;

  localparam int CFG_W    = 9;
  localparam int MODE_LSB = 6;
  localparam int FILL_CYC = 3;
  localparam int FILL_W   = $clog2(FILL_CYC + 1);

  typedef enum logic [2:0] {
    TM_OFF   = 3'b000,
    TM_RISE  = 3'b001,
    TM_FALL  = 3'b010,
    TM_ANY   = 3'b011,
    TM_LOW   = 3'b100,
    TM_OFF_A = 3'b101,
    TM_HIGH  = 3'b110,
    TM_OFF_B = 3'b111
  } trig_mode_e;

endpackage

// File: rtl/evtrig_sync.sv
module evtrig_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic flush_i,
  input  logic pin_i,
  output logic cur_o,
  output logic prev_o
);

  logic s1_q, s2_q, hist_q;
  logic s1_d, s2_d, hist_d;

  // a flush drops every sample taken from the old source
  always_comb begin
    if (flush_i) begin
      s1_d   = 1'b0;
      s2_d   = 1'b0;
      hist_d = 1'b0;
    end else begin
      s1_d   = pin_i;
      s2_d   = s1_q;
      hist_d = s2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      hist_q <= 1'b0;
    end else begin
      s1_q   <= s1_d;
      s2_q   <= s2_d;
      hist_q <= hist_d;
    end
  end

  assign cur_o  = s2_q;
  assign prev_o = hist_q;

endmodule

// File: rtl/evtrig_detect.sv
module evtrig_detect
  import evtrig_pkg::*;
(
  input  trig_mode_e mode_i,
  input  logic       cur_i,
  input  logic       prev_i,
  output logic       hit_o
);

  always_comb begin
    unique case (mode_i)
      TM_RISE: hit_o = cur_i & ~prev_i;
      TM_FALL: hit_o = ~cur_i & prev_i;
      TM_ANY:  hit_o = cur_i ^ prev_i;
      TM_LOW:  hit_o = ~cur_i;
      TM_HIGH: hit_o = cur_i;
      default: hit_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/evtrig_channel.sv
module evtrig_channel
  import evtrig_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int CNT_W    = 32,
  localparam int PIN_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic [CNT_W-1:0]    sys_cnt_i,
  input  logic                cfg_we_i,
  input  logic [CFG_W-1:0]    cfg_word_i,
  input  logic                poll_req_i,
  output logic                poll_flag_o,
  input  logic                wait_req_i,
  input  logic                wait_use_to_i,
  input  logic [CNT_W-1:0]    wait_deadline_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                timeout_o
);

  trig_mode_e        mode_q, mode_d;
  logic [PIN_W-1:0]  pin_q, pin_d;
  logic [FILL_W-1:0] fill_q, fill_d;
  logic              flag_q, flag_d;
  logic              busy_q, busy_d;
  logic              use_to_q, use_to_d;
  logic [CNT_W-1:0]  dl_q;
  logic              done_q, done_d;
  logic              to_q, to_d;
  logic              poll_q, poll_d;
  logic              start_wait;

  logic sel_pin, cur, prev, hit_raw, evt_new, pending;

  assign sel_pin = (int'(pin_q) < NUM_PINS) ? pins_i[pin_q] : 1'b0;

  evtrig_sync u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .flush_i(cfg_we_i),
    .pin_i  (sel_pin),
    .cur_o  (cur),
    .prev_o (prev)
  );

  evtrig_detect u_detect (
    .mode_i(mode_q),
    .cur_i (cur),
    .prev_i(prev),
    .hit_o (hit_raw)
  );

  // detection counts only once the pipeline holds new-source samples
  assign evt_new = hit_raw & (fill_q == '0) & ~cfg_we_i;
  assign pending = ~cfg_we_i & (flag_q | evt_new);

  always_comb begin
    mode_d     = mode_q;
    pin_d      = pin_q;
    fill_d     = fill_q;
    flag_d     = flag_q | evt_new;
    busy_d     = busy_q;
    use_to_d   = use_to_q;
    done_d     = 1'b0;
    to_d       = to_q;
    poll_d     = 1'b0;
    start_wait = 1'b0;

    if (fill_q != '0) fill_d = fill_q - 1'b1;

    if (poll_req_i && !cfg_we_i) begin
      poll_d = pending;
      flag_d = 1'b0;
    end

    if (busy_q) begin
      if (pending) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        to_d   = 1'b0;
        flag_d = 1'b0;
      end else if (use_to_q && (sys_cnt_i == dl_q)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        to_d   = 1'b1;
      end
    end else if (wait_req_i) begin
      busy_d     = 1'b1;
      use_to_d   = wait_use_to_i;
      start_wait = 1'b1;
    end

    if (cfg_we_i) begin
      mode_d = trig_mode_e'(cfg_word_i[MODE_LSB +: 3]);
      pin_d  = cfg_word_i[PIN_W-1:0];
      fill_d = FILL_W'(FILL_CYC);
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= TM_OFF;
      pin_q    <= '0;
      fill_q   <= '0;
      flag_q   <= 1'b0;
      busy_q   <= 1'b0;
      use_to_q <= 1'b0;
      done_q   <= 1'b0;
      to_q     <= 1'b0;
      poll_q   <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      pin_q    <= pin_d;
      fill_q   <= fill_d;
      flag_q   <= flag_d;
      busy_q   <= busy_d;
      use_to_q <= use_to_d;
      done_q   <= done_d;
      to_q     <= to_d;
      poll_q   <= poll_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dl_q <= '0;
    end else if (start_wait) begin
      dl_q <= wait_deadline_i;
    end
  end

  assign poll_flag_o = poll_q;
  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign timeout_o   = to_q;

  // R6: a write during a wait can never end it on an event in the next cycle
  a_r6_no_stale_end: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && cfg_we_i) |=> !(done_o && !timeout_o));

  // R6: poll result right after a write reports nothing
  a_r6_poll_masked: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we_i |=> !poll_flag_o);

  // R7: a poll result only follows a poll strobe
  a_r7_poll_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    poll_flag_o |-> $past(poll_req_i));

  // R8: the end pulse comes only as busy drops
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  a_r8_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  // R9: a timeout ends exactly one count past the deadline
  a_r9_timeout_cnt: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && timeout_o) |-> (sys_cnt_i == dl_q + 1'b1));

endmodule

// File: rtl/evtrig_unit.sv
module evtrig_unit
  import evtrig_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int CNT_W    = 32,
  parameter int NUM_CH   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pins_i,
  output logic [CNT_W-1:0]    sys_cnt_o,
  input  logic [NUM_CH-1:0]   cfg_we_i,
  input  logic [CFG_W-1:0]    cfg_word_i,
  input  logic [NUM_CH-1:0]   poll_req_i,
  output logic [NUM_CH-1:0]   poll_flag_o,
  input  logic [NUM_CH-1:0]   wait_req_i,
  input  logic [NUM_CH-1:0]   wait_use_to_i,
  input  logic [CNT_W-1:0]    wait_deadline_i,
  output logic [NUM_CH-1:0]   busy_o,
  output logic [NUM_CH-1:0]   done_o,
  output logic [NUM_CH-1:0]   timeout_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign cnt_d = cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign sys_cnt_o = cnt_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    evtrig_channel #(
      .NUM_PINS(NUM_PINS),
      .CNT_W   (CNT_W)
    ) u_ch (
      .clk            (clk),
      .rst_n          (rst_n),
      .pins_i         (pins_i),
      .sys_cnt_i      (cnt_q),
      .cfg_we_i       (cfg_we_i[c]),
      .cfg_word_i     (cfg_word_i),
      .poll_req_i     (poll_req_i[c]),
      .poll_flag_o    (poll_flag_o[c]),
      .wait_req_i     (wait_req_i[c]),
      .wait_use_to_i  (wait_use_to_i[c]),
      .wait_deadline_i(wait_deadline_i),
      .busy_o         (busy_o[c]),
      .done_o         (done_o[c]),
      .timeout_o      (timeout_o[c])
    );
  end

  // R11: the system counter steps by one every cycle
  a_r11_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rst_n) || (sys_cnt_o == $past(sys_cnt_o) + 1'b1) || ($past(sys_cnt_o) == '0 && sys_cnt_o == '0));

endmodule

// File: tb/evtrig_unit_bench.sv
module evtrig_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] pins;
  logic [31:0] sys_cnt;
  logic [1:0]  cfg_we, poll_req, poll_flag, wait_req, wait_use_to;
  logic [8:0]  cfg_word;
  logic [31:0] deadline;
  logic [1:0]  busy, done, tmo;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  evtrig_unit u_evtrig_unit (
    .clk            (clk),
    .rst_n          (rst_n),
    .pins_i         (pins),
    .sys_cnt_o      (sys_cnt),
    .cfg_we_i       (cfg_we),
    .cfg_word_i     (cfg_word),
    .poll_req_i     (poll_req),
    .poll_flag_o    (poll_flag),
    .wait_req_i     (wait_req),
    .wait_use_to_i  (wait_use_to),
    .wait_deadline_i(deadline),
    .busy_o         (busy),
    .done_o         (done),
    .timeout_o      (tmo)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_fire(input logic [2:0] m, input bit b, input bit n);
    case (m)
      3'b001:  return !b && n;
      3'b010:  return b && !n;
      3'b011:  return b != n;
      3'b100:  return !n;
      3'b110:  return n;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] m);
    if (m == 3'b100 || m == 3'b110) return "R3";
    if (m == 3'b001 || m == 3'b010 || m == 3'b011) return "R4";
    return "R5";
  endfunction

  task automatic configure(input int ch, input logic [2:0] m, input int p);
    cfg_word   = {m, 2'b00, 4'(p)};
    cfg_we[ch] = 1'b1;
    step();
    cfg_we[ch] = 1'b0;
  endtask

  task automatic pulse_poll(input int ch);
    poll_req[ch] = 1'b1;
    step();
    poll_req[ch] = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5821));
    rst_n = 1'b0; pins = '0; cfg_we = '0; cfg_word = '0; poll_req = '0;
    wait_req = '0; wait_use_to = '0; deadline = '0;
    repeat (3) step();
    // R1 reset state
    chk("R1 busy", busy, 0); chk("R1 done", done, 0);
    chk("R1 timeout", tmo, 0); chk("R1 poll", poll_flag, 0);
    chk("R1 cnt", sys_cnt, 0);
    rst_n = 1'b1;
    step();
    chk("R1 busy after", busy, 0);

    // R11 counter steps
    begin
      logic [31:0] c0;
      c0 = sys_cnt;
      repeat (5) step();
      chk("R11 count", sys_cnt, c0 + 5);
    end

    // random sweep of codes, lines and transitions on channel 0 (R2 R3 R4 R5 R9)
    for (int i = 0; i < 40; i++) begin
      int p;
      logic [2:0] m;
      bit b, n;
      logic [31:0] dl;
      p = int'($urandom % 16);
      m = 3'($urandom % 8);
      b = 1'($urandom % 2);
      if (m == 3'b110) b = 1'b0;
      if (m == 3'b100) b = 1'b1;
      n = (m == 3'b110 || m == 3'b100) ? ~b : 1'($urandom % 2);
      pins[p] = b;
      configure(0, m, p);
      repeat (5) step();
      dl = sys_cnt + 12;
      deadline = dl; wait_use_to[0] = 1'b1; wait_req[0] = 1'b1;
      step();
      wait_req[0] = 1'b0;
      pins[p] = n;
      chk("R8 busy", busy[0], 1);
      step(); chk({tag_of(m), " early1"}, done[0], 0);
      step(); chk({tag_of(m), " early2"}, done[0], 0);
      step();
      if (exp_fire(m, b, n)) begin
        chk({tag_of(m), " R2 fire"}, done[0], 1);
        chk({tag_of(m), " no timeout"}, tmo[0], 0);
      end else begin
        chk({tag_of(m), " R2 quiet"}, done[0], 0);
        for (int k = 0; k < 20 && !done[0]; k++) step();
        chk("R9 timeout flag", tmo[0], 1);
        chk("R9 timeout count", sys_cnt, dl + 1);
      end
      step();
    end
    wait_use_to = '0;

    // R6 R7: level already true at write; poll together with the write returns 0
    pins[7] = 1'b1;
    poll_req[1] = 1'b1;
    configure(1, 3'b110, 7);
    chk("R7 poll with write", poll_flag[1], 0);
    step(); chk("R6 mask1", poll_flag[1], 0);
    step(); chk("R6 mask2", poll_flag[1], 0);
    step(); chk("R6 mask3", poll_flag[1], 0);
    step(); chk("R6 level seen", poll_flag[1], 1);
    poll_req[1] = 1'b0;
    repeat (3) step();

    // R6: stale high level on old line must not end a wait issued with the write
    pins[9] = 1'b0;
    cfg_word = {3'b110, 2'b00, 4'd9};
    cfg_we[1] = 1'b1; wait_req[1] = 1'b1;
    step();
    cfg_we[1] = 1'b0; wait_req[1] = 1'b0;
    for (int k = 0; k < 10; k++) begin
      chk("R6 stays busy", busy[1], 1);
      chk("R6 no stale end", done[1], 0);
      step();
    end
    pins[9] = 1'b1;
    step(); chk("R6 new early1", done[1], 0);
    step(); chk("R6 new early2", done[1], 0);
    step(); chk("R6 new fires", done[1], 1); chk("R6 not timeout", tmo[1], 0);
    repeat (4) step();

    // R8: wait with event already pending ends after W+1
    wait_req[1] = 1'b1;
    step();
    wait_req[1] = 1'b0;
    chk("R8 busy at W", busy[1], 1); chk("R8 no done at W", done[1], 0);
    step();
    chk("R8 done at W+1", done[1], 1);
    pins[9] = 1'b0;
    repeat (4) step();
    pins[9] = 1'b1;
    repeat (5) step();

    // R7: poll returns then clears
    pins[4] = 1'b0;
    configure(0, 3'b001, 4);
    repeat (5) step();
    pins[4] = 1'b1;
    repeat (5) step();
    pulse_poll(0); chk("R7 poll set", poll_flag[0], 1);
    pulse_poll(0); chk("R7 poll cleared", poll_flag[0], 0);

    // R5: all-zero word cancels a pending event
    pins[2] = 1'b0;
    configure(0, 3'b001, 2);
    repeat (5) step();
    pins[2] = 1'b1;
    repeat (5) step();
    configure(0, 3'b000, 2);
    for (int k = 0; k < 4; k++) begin
      pins[2] = ~pins[2];
      repeat (4) step();
    end
    pulse_poll(0); chk("R5 cancelled", poll_flag[0], 0);

    // R10: channel 1 (high on line 9, still active) unaffected by channel 0 work
    configure(0, 3'b110, 9);
    configure(0, 3'b011, 3);
    pulse_poll(0);
    pulse_poll(1); chk("R10 other channel pending", poll_flag[1], 1);
    chk("R10 ch0 idle", busy[0], 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule